// File: doc/BRIEF.md
# Burst Address Counter Register

This block produces the internal address that one port of a burst-capable memory uses in every cycle. At each rising clock edge it acts on three active-low controls. It can load an externally supplied address, step its stored address up by one, keep the stored address as it is, or clear it to zero. Because of this, a host can present one start address and then stream through consecutive locations without driving the address bus again.

The controls follow a fixed priority: clear first, then strobe, then step. If none of them is asserted, the stored address holds and the external address has no effect. The block has no port-select input, so it steps and loads whether or not the memory port is in use. Stepping past the highest address wraps the count to zero. The address bus width and the number of bits the array actually uses are separate parameters. In a half-depth variant, the unused top bits read as zero and are never loaded from the external address.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst_n` is low, `cur_addr` is zero.
- R2: If `clear_n` is low at a rising edge, `cur_addr` is zero after that edge, whatever `strobe_n`, `step_n` and `ext_addr` are.
- R3: If `clear_n` is high and `strobe_n` is low at a rising edge, `cur_addr` after that edge equals `ext_addr`, restricted to its low `USED_W` bits. The value of `step_n` does not matter.
- R4: If `clear_n` and `strobe_n` are high and `step_n` is low at a rising edge, `cur_addr` after that edge is the previous `cur_addr` plus one.
- R5: If `clear_n`, `strobe_n` and `step_n` are all high at a rising edge, `cur_addr` is unchanged and `ext_addr` has no effect.
- R6: Stepping from the highest usable address, all `USED_W` low bits ones, gives zero.
- R7: When `USED_W` is less than `ADDR_W`, bits `ADDR_W-1` down to `USED_W` of `cur_addr` are always zero. The matching bits of `ext_addr` are ignored on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to address zero |
| ext_addr | input | ADDR_W | External start address |
| strobe_n | input | 1 | Active-low load of `ext_addr` |
| step_n | input | 1 | Active-low increment |
| clear_n | input | 1 | Active-low clear to zero, highest priority |
| cur_addr | output | ADDR_W | Internal address used this cycle |

## Verification
Wrap-around is the hardest case to reach from the ports, because stepping up from zero takes 2^USED_W cycles to get there. The stimulus instead loads the all-ones address through the strobe and then steps once. A narrow instance with 13 used bits gets the same treatment, and its loads have the top external bit set to show that this bit never reaches the output. Random traffic with all three controls asserted together at different rates covers the priority order. The bench checks every cycle against a model of that order.

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int ADDR_W = 14,
  parameter int USED_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int SPARE_W = ADDR_W - USED_W;
  localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'({USED_W{1'b1}});

  logic [USED_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!clear_n)
      cnt_q <= '0;
    else if (!strobe_n)
      cnt_q <= ext_addr[USED_W-1:0];
    else if (!step_n)
      cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (SPARE_W > 0) begin : g_pad
      assign cur_addr = {{SPARE_W{1'b0}}, cnt_q};
    end else begin : g_full
      assign cur_addr = cnt_q;
    end
  endgenerate

  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (cur_addr == '0); // R1
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> cur_addr == '0); // R2

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !strobe_n) |=> cur_addr == ($past(ext_addr) & KEEP_MASK)); // R3

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && strobe_n && !step_n) |=> cur_addr == (($past(cur_addr) + 1'b1) & KEEP_MASK)); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && strobe_n && step_n) |=> $stable(cur_addr)); // R5

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && strobe_n && !step_n && cur_addr == KEEP_MASK) |=> cur_addr == '0); // R6

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_addr & ~KEEP_MASK) == '0); // R7

endmodule

// File: tb/test_burst_addr_ctr.sv
module test_burst_addr_ctr;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          step_n = 1'b1;
  logic          clear_n = 1'b1;
  logic [AW-1:0] cur_full;
  logic [AW-1:0] cur_narrow;
  logic [AW-1:0] exp_full;
  logic [AW-1:0] exp_narrow;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(AW), .USED_W(AW)) i_burst_addr_ctr (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .step_n(step_n), .clear_n(clear_n), .cur_addr(cur_full));

  burst_addr_ctr #(.ADDR_W(AW), .USED_W(AW-1)) i_burst_addr_ctr_half (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .step_n(step_n), .clear_n(clear_n), .cur_addr(cur_narrow));

  function automatic logic [AW-1:0] model(logic [AW-1:0] cur, logic [AW-1:0] ext,
                                          logic s, logic e, logic c, int used);
    logic [AW-1:0] m;
    m = (14'd1 << used) - 14'd1;
    if (!c)      return '0;
    else if (!s) return ext & m;
    else if (!e) return (cur + 14'd1) & m;
    else         return cur;
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_cycle(logic [AW-1:0] a, logic s, logic e, logic c, string tag);
    ext_addr = a; strobe_n = s; step_n = e; clear_n = c;
    exp_full   = model(exp_full, a, s, e, c, AW);
    exp_narrow = model(exp_narrow, a, s, e, c, AW-1);
    @(posedge clk);
    @(negedge clk);
    check({tag, " full"}, cur_full, exp_full);
    check({tag, " half"}, cur_narrow, exp_narrow);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    exp_full = '0; exp_narrow = '0;
    ext_addr = 14'h3ABC; strobe_n = 1'b0; step_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset full", cur_full, '0);
    check("R1 reset half", cur_narrow, '0);
    strobe_n = 1'b1; step_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);

    step_cycle(14'h1234, 1'b0, 1'b1, 1'b1, "R3 load");
    step_cycle(14'h0000, 1'b1, 1'b0, 1'b1, "R4 step");
    step_cycle(14'h2222, 1'b1, 1'b1, 1'b1, "R5 hold ignores ext");
    step_cycle(14'h0F0F, 1'b0, 1'b0, 1'b1, "R3 load beats step");
    step_cycle(14'h0555, 1'b0, 1'b0, 1'b0, "R2 clear beats all");
    step_cycle(14'h3FFF, 1'b0, 1'b1, 1'b1, "R7 load top bit dropped");
    step_cycle(14'h0000, 1'b1, 1'b0, 1'b1, "R6 wrap to zero");
    step_cycle(14'h1FFF, 1'b0, 1'b1, 1'b1, "R3 load half max");
    step_cycle(14'h0000, 1'b1, 1'b0, 1'b1, "R6 half wrap");

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if ($urandom_range(0, 7) == 0) a = 14'h3FFF;
      step_cycle(a, $urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0,
                 $urandom_range(0, 15) != 0, "R2 R3 R4 R5 R7 random");
    end

    step_cycle(14'h3FFF, 1'b0, 1'b1, 1'b1, "R3 load max");
    for (int i = 0; i < 3; i++)
      step_cycle(14'h1111, 1'b1, 1'b0, 1'b1, "R6 R4 step across wrap");
    step_cycle(14'h2AAA, 1'b1, 1'b1, 1'b1, "R5 final hold");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule